// File: doc/BRIEF.md
# CEC Start Bit Transmitter

This block produces the opening start bit of a CEC frame on a shared open-drain line and confirms that no other node has damaged it. Software, or a frame controller, raises a one-cycle request. The block records it as a pending start-of-message. It then pulls the line low, which sets the time reference, and lets go after 3.7 ms. From then on it watches the synchronised line level. The line must rise before a deadline. After that, it must not fall again before a second limit. Both limits depend on the tolerance-mode input.

A good start bit ends at 4.5 ms. At that point the block pulls the line low for one cycle and gives a start-done pulse, so the data-bit sequencer can take over. A damaged start bit gives a one-cycle error pulse and clears the pending request. The transfer is not retried, and the block does not stall with a request stuck high. Taking the enable input low aborts any transfer and discards the request.

All timing is counted in ticks of 50 us, made by a prescaler (`CLKS_PER_TICK` clocks per tick). Tick limits: release 74, rise limit 78 (normal) or 81 (extended), early-fall limit 86 (normal) or 83 (extended), next bit 90.

States:
- `ST_IDLE`: waiting for a request.
- `ST_DRIVE`: pulling the line low.
- `ST_WAIT_HI`: line released, waiting for it to read high.
- `ST_HOLD_HI`: high phase, watching for an early falling edge.
- `ST_DONE`: one cycle, success.
- `ST_FAIL`: one cycle, error.

Transitions:
- IDLE to DRIVE: a request is pending.
- DRIVE to WAIT_HI: the elapsed count equals 74.
- WAIT_HI to HOLD_HI: the line reads high.
- WAIT_HI to FAIL: the line is still low and the elapsed count is above the rise limit.
- HOLD_HI to FAIL: a falling edge is seen below the early-fall limit.
- HOLD_HI to DONE: the elapsed count equals 90.
- DONE to IDLE and FAIL to IDLE: always, after one cycle.
- Any state to IDLE: enable is low.

Top module: `cec_start_tx`

## Requirements
- R1: After reset the line is released, no request is pending, and `start_done` and `start_err` are low.
- R2: While enabled, a request pulse makes `som_pending` high on the next cycle. The cycle after that, `line_drive_low` goes high and stays high until the elapsed count of 74 ticks is reached.
- R3: After release, the line must read high while the elapsed count is at most 78 ticks with `ext_tol`=0, or at most 81 ticks with `ext_tol`=1. Otherwise the start bit fails.
- R4: In the high phase, a falling edge seen below 86 ticks (`ext_tol`=0) or below 83 ticks (`ext_tol`=1) fails the start bit. A falling edge at or after that limit is ignored.
- R5: A failed start bit gives exactly one `start_err` cycle and clears `som_pending`. The line then stays released with no retry.
- R6: A valid start bit gives exactly one `start_done` cycle at 90 ticks. The line is driven low in that cycle and `som_pending` is cleared.
- R7: Enable low returns the block to idle on the next cycle. This releases the line and clears `som_pending`. Requests made while disabled are ignored.
- R8: A request that arrives in the same cycle as `start_done` or `start_err` is ignored, because the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low aborts and clears the request |
| ext_tol | input | 1 | 1 selects the extended timing tolerances |
| som_req | input | 1 | One-cycle start-of-message request |
| line_in | input | 1 | Raw level of the CEC line (asynchronous) |
| line_drive_low | output | 1 | 1 pulls the open-drain line low |
| som_pending | output | 1 | A start-of-message request is pending |
| start_done | output | 1 | One-cycle pulse: start bit valid, next bit begins |
| start_err | output | 1 | One-cycle pulse: start bit corrupted |

## Verification
Two functions can land on the same clock edge: taking in a new request, and the clear that ends a transfer. The bench provokes this by raising `som_req` in the same cycle that `start_done` is seen. It then judges that `som_pending` reads low on the next cycle. A second collision occurs when enable falls during the low drive. The bench checks that the abort wins over the running timers, with no later error or done pulse. Every cycle, a behavioural model is compared against all four outputs, including at the exact 78-tick rise boundary.

// File: rtl/cec_start_pkg.sv
package cec_start_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_WAIT_HI,
        ST_HOLD_HI,
        ST_DONE,
        ST_FAIL
    } start_state_e;

endpackage

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
    parameter int CLKS_PER_TICK = 2500,
    parameter int CNT_W         = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] elapsed
);
    localparam int PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;

    logic [PRE_W-1:0] pre_q;
    logic             tick;

    assign tick = (pre_q == PRE_W'(CLKS_PER_TICK - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            elapsed <= '0;
        end else if (!run) begin
            pre_q   <= '0;
            elapsed <= '0;
        end else begin
            pre_q   <= tick ? '0 : pre_q + 1'b1;
            elapsed <= elapsed + CNT_W'(tick);
        end
    end

    // R2: the time reference advances by at most one tick per clock while running
    a_r2_elapsed_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && elapsed != {CNT_W{1'b1}}) |=> (elapsed == $past(elapsed) || elapsed == $past(elapsed) + 1'b1 || elapsed == '0));

endmodule

// File: rtl/cec_line_sync.sv
module cec_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_hi,
    output logic line_fall
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= line_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain[STAGES-1];
    end

    assign line_hi   = chain[STAGES-1];
    assign line_fall = prev_q & ~chain[STAGES-1];

endmodule

// File: rtl/cec_start_fsm.sv
module cec_start_fsm
    import cec_start_pkg::*;
#(
    parameter int CNT_W      = 7,
    parameter int REL_TICKS  = 74,
    parameter int RISE_NORM  = 78,
    parameter int RISE_EXT   = 81,
    parameter int FALL_NORM  = 86,
    parameter int FALL_EXT   = 83,
    parameter int NEXT_TICKS = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ext_tol,
    input  logic             som_req,
    input  logic             line_hi,
    input  logic             line_fall,
    input  logic [CNT_W-1:0] elapsed,
    output logic             run,
    output logic             drive_low,
    output logic             pending,
    output logic             done,
    output logic             err
);
    start_state_e     state, state_nxt;
    logic [CNT_W-1:0] rise_lim;
    logic [CNT_W-1:0] fall_lim;

    assign rise_lim = ext_tol ? CNT_W'(RISE_EXT) : CNT_W'(RISE_NORM);
    assign fall_lim = ext_tol ? CNT_W'(FALL_EXT) : CNT_W'(FALL_NORM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (!enable) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (pending) state_nxt = ST_DRIVE;
                ST_DRIVE:   if (elapsed == CNT_W'(REL_TICKS)) state_nxt = ST_WAIT_HI;
                ST_WAIT_HI: begin
                    if (line_hi)                state_nxt = ST_HOLD_HI;
                    else if (elapsed > rise_lim) state_nxt = ST_FAIL;
                end
                ST_HOLD_HI: begin
                    if (line_fall && elapsed < fall_lim)       state_nxt = ST_FAIL;
                    else if (elapsed == CNT_W'(NEXT_TICKS))    state_nxt = ST_DONE;
                end
                ST_DONE:    state_nxt = ST_IDLE;
                ST_FAIL:    state_nxt = ST_IDLE;
                default:    state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  pending <= 1'b0;
        else if (!enable)                            pending <= 1'b0;
        else if (state == ST_DONE || state == ST_FAIL) pending <= 1'b0;
        else if (som_req)                            pending <= 1'b1;
    end

    always_comb begin
        run       = (state == ST_DRIVE) || (state == ST_WAIT_HI) || (state == ST_HOLD_HI);
        drive_low = (state == ST_DRIVE) || (state == ST_DONE);
        done      = (state == ST_DONE);
        err       = (state == ST_FAIL);
    end

    // R2: low drive is held until the release count
    a_r2_hold_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_DRIVE && elapsed < CNT_W'(REL_TICKS)) |=> drive_low);

    // R3: a line still low past the rise limit must end in an error
    a_r3_late_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_WAIT_HI && !line_hi && elapsed > rise_lim) |=> err);

    // R5: error is a single cycle and leaves nothing pending or driven
    a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && !pending && !drive_low));

    // R6: done is a single cycle and clears the request
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !pending));

    // R7: disabling returns to idle with nothing pending
    a_r7_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pending && !drive_low && !run));

endmodule

// File: rtl/cec_start_tx.sv
module cec_start_tx #(
    parameter int CLKS_PER_TICK = 2500,
    parameter int SYNC_STAGES   = 2,
    parameter int REL_TICKS     = 74,
    parameter int RISE_NORM     = 78,
    parameter int RISE_EXT      = 81,
    parameter int FALL_NORM     = 86,
    parameter int FALL_EXT      = 83,
    parameter int NEXT_TICKS    = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ext_tol,
    input  logic som_req,
    input  logic line_in,
    output logic line_drive_low,
    output logic som_pending,
    output logic start_done,
    output logic start_err
);
    localparam int CNT_W = $clog2(NEXT_TICKS + 2);

    logic             run;
    logic             line_hi;
    logic             line_fall;
    logic [CNT_W-1:0] elapsed;

    cec_tick_gen #(
        .CLKS_PER_TICK(CLKS_PER_TICK),
        .CNT_W        (CNT_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .elapsed(elapsed)
    );

    cec_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .line_hi  (line_hi),
        .line_fall(line_fall)
    );

    cec_start_fsm #(
        .CNT_W     (CNT_W),
        .REL_TICKS (REL_TICKS),
        .RISE_NORM (RISE_NORM),
        .RISE_EXT  (RISE_EXT),
        .FALL_NORM (FALL_NORM),
        .FALL_EXT  (FALL_EXT),
        .NEXT_TICKS(NEXT_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .ext_tol  (ext_tol),
        .som_req  (som_req),
        .line_hi  (line_hi),
        .line_fall(line_fall),
        .elapsed  (elapsed),
        .run      (run),
        .drive_low(line_drive_low),
        .pending  (som_pending),
        .done     (start_done),
        .err      (start_err)
    );

    // R6: success and failure never coincide at the ports
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |-> !start_err);

endmodule

// File: tb/cec_start_tx_tb.sv
module cec_start_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P    = 2;
    localparam int REL  = 74;
    localparam int RN   = 78;
    localparam int RE   = 81;
    localparam int FN   = 86;
    localparam int FE   = 83;
    localparam int NXT  = 90;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic ext_tol = 1'b0;
    logic som_req = 1'b0;
    logic corrupt = 1'b0;
    logic line_w;
    logic line_drive_low, som_pending, start_done, start_err;

    int n_vec = 0;
    int n_miss = 0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_w = ~(line_drive_low | corrupt);

    cec_start_tx #(
        .CLKS_PER_TICK(P), .SYNC_STAGES(2), .REL_TICKS(REL), .RISE_NORM(RN),
        .RISE_EXT(RE), .FALL_NORM(FN), .FALL_EXT(FE), .NEXT_TICKS(NXT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ext_tol(ext_tol),
        .som_req(som_req), .line_in(line_w), .line_drive_low(line_drive_low),
        .som_pending(som_pending), .start_done(start_done), .start_err(start_err)
    );

    // behavioural reference: phase 0 idle,1 low,2 await high,3 high,4 done,5 fail
    int m_ph = 0;
    int m_cyc = 0;
    bit m_pend = 0;
    bit m_hist [$] = '{1'b1, 1'b1, 1'b1};

    always @(posedge clk) begin
        bit hi, fall, np;
        int ms, nph;
        if (!rst_n) begin
            m_ph = 0; m_cyc = 0; m_pend = 0;
            m_hist = '{1'b1, 1'b1, 1'b1};
        end else begin
            hi   = m_hist[1];
            fall = m_hist[2] && !m_hist[1];
            ms   = m_cyc / P;
            nph  = m_ph;
            np   = m_pend;
            if (!enable) begin
                nph = 0; np = 0;
            end else begin
                if (m_ph == 4 || m_ph == 5) np = 0;
                else if (som_req)            np = 1;
                case (m_ph)
                    0: if (m_pend) begin nph = 1; m_cyc = -1; end
                    1: if (ms == REL) nph = 2;
                    2: if (hi) nph = 3; else if (ms > (ext_tol ? RE : RN)) nph = 5;
                    3: if (fall && ms < (ext_tol ? FE : FN)) nph = 5; else if (ms == NXT) nph = 4;
                    default: nph = 0;
                endcase
            end
            m_cyc++;
            m_ph = nph;
            m_pend = np;
            m_hist.push_front(line_w);
            void'(m_hist.pop_back());
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(line_drive_low == (m_ph == 1 || m_ph == 4), "R2 drive", line_drive_low, (m_ph == 1 || m_ph == 4));
            check(som_pending == m_pend, "R7 pending", som_pending, m_pend);
            check(start_done == (m_ph == 4), "R6 done", start_done, (m_ph == 4));
            check(start_err == (m_ph == 5), "R5 err", start_err, (m_ph == 5));
        end
    end

    task automatic frame(input bit ext, input int hold_until, input int pulse_at,
                         input int exp_done, input int exp_err, input bit req_at_end,
                         input string tag);
        int dn, er, w;
        dn = 0; er = 0; w = 0;
        ext_tol = ext;
        @(negedge clk); som_req = 1'b1;
        @(negedge clk); som_req = 1'b0;
        while (!line_drive_low && w < 10) begin @(negedge clk); w++; end
        check(line_drive_low, {tag, " R2 start"}, line_drive_low, 1);
        for (int c = 0; c < 230; c++) begin
            som_req = 1'b0;
            corrupt = (c < hold_until) || (pulse_at > 0 && c >= pulse_at && c < pulse_at + 4);
            if (start_done) dn++;
            if (start_err)  er++;
            if (req_at_end && (start_done || start_err)) som_req = 1'b1;
            @(negedge clk);
        end
        corrupt = 1'b0;
        check(dn == exp_done, {tag, " R6 done count"}, dn, exp_done);
        check(er == exp_err,  {tag, " R5 err count"}, er, exp_err);
        check(!som_pending,   {tag, " R8 pending cleared"}, som_pending, 0);
        check(!line_drive_low, {tag, " R5 no retry"}, line_drive_low, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        check(!line_drive_low && !som_pending && !start_done && !start_err, "R1 reset", {line_drive_low, som_pending, start_done, start_err}, 0);
        enable = 1'b1;
        @(negedge clk);
        frame(0, 0,   0,   1, 0, 0, "R6 clean");
        frame(0, 160, 0,   0, 1, 0, "R3 late rise");
        frame(0, 154, 0,   1, 0, 0, "R3 boundary rise");
        frame(1, 160, 0,   1, 0, 0, "R3 ext rise");
        frame(0, 0,   168, 0, 1, 0, "R4 early fall");
        frame(1, 0,   168, 1, 0, 0, "R4 ext fall");
        frame(0, 0,   174, 1, 0, 0, "R4 late fall");
        frame(1, 156, 0,   1, 0, 1, "R8 req at done");
        frame(0, 170, 0,   0, 1, 1, "R8 req at err");
        // R7: abort during the low drive
        som_req = 1'b1; @(negedge clk); som_req = 1'b0;
        repeat (40) @(negedge clk);
        enable = 1'b0; @(negedge clk);
        check(!som_pending && !line_drive_low, "R7 abort", {som_pending, line_drive_low}, 0);
        som_req = 1'b1; @(negedge clk); som_req = 1'b0;
        repeat (5) @(negedge clk);
        check(!som_pending, "R7 request while disabled", som_pending, 0);
        enable = 1'b1;
        begin
            int pulses;
            pulses = 0;
            for (int c = 0; c < 200; c++) begin
                if (start_done || start_err || line_drive_low) pulses++;
                @(negedge clk);
            end
            check(pulses == 0, "R7 quiet after abort", pulses, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_miss++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule